// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block lives in the byte datapath of an SMBus host controller and takes care of the packet error code without software help. The shifter presents each byte it sends or receives as a single-cycle strobe. The strobe carries the byte's direction and a marker on the final byte of the packet. A start-condition pulse separates packets. While automatic mode is enabled, the engine folds every byte into a CRC-8, and that includes the address byte or bytes.

At the end of a write packet, the engine asserts an append pulse. The shifter then transmits the CRC byte that the engine presents on `pec_byte`. At the end of a read packet, the final received byte is the PEC. The engine compares it against the CRC of everything received before it. A mismatch raises two sticky flags: a general device-error flag and a dedicated CRC-error flag.

The software PEC data value is used only in manual mode. If the automatic enable and the manual enable are set together, the engine raises a sticky configuration-conflict flag and suppresses the append.

Top module: `pec_engine`

## Requirements
- R1: The checksum is CRC-8 with polynomial 0x07, seed 0x00, and bits fed most significant first. In automatic mode it covers every strobed byte of the packet, address bytes included. For example, the ASCII bytes "123456789" give 0xF4.
- R2: In automatic mode, a transmit strobe (`byte_rx`=0) with `byte_last`=1 makes `pec_append` high for the single following cycle. In that same cycle, `pec_byte` equals the CRC over all bytes of the packet, the final one included.
- R3: In automatic mode, a receive strobe (`byte_rx`=1) with `byte_last`=1 is compared with the CRC of the earlier bytes of the packet. On a mismatch, `dev_err` and `crc_err` are both high from the following cycle.
- R4: A receive packet whose final byte equals the CRC of the earlier bytes leaves `dev_err` and `crc_err` low.
- R5: A `start_evt` pulse reseeds the CRC to 0x00. A byte strobed in the same cycle as the pulse becomes the first byte of the new packet.
- R6: In automatic mode, `pec_byte` always carries the engine's CRC and never `sw_pec_data`. In manual mode (`manual_pec_en`=1, `auto_en`=0), `pec_byte` equals `sw_pec_data`, and a final transmit strobe still gives `pec_append` in the next cycle.
- R7: While `auto_en` and `manual_pec_en` are both high, `cfg_conflict` is set from the next cycle and no `pec_append` is produced.
- R8: The three flags stay set until cleared by a one-cycle pulse on `status_clr`. The bit mapping is: bit 0 clears `dev_err`, bit 1 clears `crc_err`, bit 2 clears `cfg_conflict`. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: With `auto_en`=0, strobed bytes neither change the CRC nor trigger a comparison.
- R10: After reset, all flags are low, `pec_append` is low, and the CRC is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic PEC enable |
| manual_pec_en | input | 1 | Software-supplied PEC enable |
| sw_pec_data | input | 8 | Software PEC byte for manual mode |
| start_evt | input | 1 | Start or repeated-start pulse |
| byte_vld | input | 1 | Byte strobe |
| byte_rx | input | 1 | 1 = received byte, 0 = transmitted byte |
| byte_last | input | 1 | Final byte of the packet |
| byte_data | input | 8 | Byte value |
| status_clr | input | 3 | Write-one-to-clear pulses for the flags |
| pec_byte | output | 8 | PEC byte for the shifter |
| pec_append | output | 1 | Send `pec_byte` now |
| dev_err | output | 1 | Sticky device-error flag |
| crc_err | output | 1 | Sticky CRC-error flag |
| cfg_conflict | output | 1 | Sticky enable-conflict flag |

## Verification
Each result is due exactly one clock edge after its stimulus. The append pulse and the final CRC follow a last transmit strobe by one edge. Both error flags follow a mismatching last receive strobe by one edge. The conflict flag follows the first cycle in which both enables are high by one edge. The bench drives every input on the falling edge, lets one rising edge pass, and samples on the following falling edge, which is the cycle in which each of these outputs must first show. Stickiness is then confirmed several idle cycles later.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FLAG_DEV = 0;
  localparam int unsigned FLAG_CRC = 1;
  localparam int unsigned FLAG_CFG = 2;
  localparam int unsigned NUM_FLAGS = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_AUTO     = 2'd1,
    MODE_MANUAL   = 2'd2,
    MODE_CONFLICT = 2'd3
  } pec_mode_e;

  // Byte-wide CRC step: fold the whole byte into the remainder, then shift
  // out one bit per iteration, most significant first.
  function automatic byte_t crc_step(byte_t acc, byte_t din, byte_t poly);
    byte_t r;
    r = acc ^ din;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      if (r[BYTE_W-1]) r = (r << 1) ^ poly;
      else             r = r << 1;
    end
    return r;
  endfunction

  function automatic pec_mode_e decode_mode(logic auto_on, logic man_on);
    pec_mode_e m;
    case ({auto_on, man_on})
      2'b10:   m = MODE_AUTO;
      2'b01:   m = MODE_MANUAL;
      2'b11:   m = MODE_CONFLICT;
      default: m = MODE_OFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pec_crc_accum.sv
module pec_crc_accum
  import pec_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reseed,
  input  logic  upd,
  input  byte_t din,
  output byte_t seed,
  output byte_t crc_q
);
  byte_t acc_r;
  byte_t nxt;

  // A reseed in the same cycle as a byte makes that byte the first one.
  assign seed = reseed ? INIT : acc_r;
  assign nxt  = crc_step(seed, din, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_r <= INIT;
    else if (upd)    acc_r <= nxt;
    else if (reseed) acc_r <= INIT;
  end

  assign crc_q = acc_r;
endmodule

// File: rtl/pec_flag_bank.sv
module pec_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;   // set outranks clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_q[g] = q;
  end
endmodule

// File: rtl/pec_ctrl.sv
module pec_ctrl
  import pec_pkg::*;
(
  input  pec_mode_e mode,
  input  logic      byte_vld,
  input  logic      byte_rx,
  input  logic      byte_last,
  input  byte_t     byte_data,
  input  byte_t     seed,
  output logic      acc_upd,
  output logic      check_evt,
  output logic      mismatch_evt,
  output logic      append_req,
  output logic      conflict_evt
);
  logic auto_on;

  assign auto_on      = (mode == MODE_AUTO) || (mode == MODE_CONFLICT);
  // The received PEC byte itself is compared, not folded in.
  assign acc_upd      = byte_vld && auto_on && !(byte_rx && byte_last);
  assign check_evt    = byte_vld && auto_on && byte_rx && byte_last;
  assign mismatch_evt = check_evt && (byte_data != seed);
  assign append_req   = byte_vld && !byte_rx && byte_last &&
                        ((mode == MODE_AUTO) || (mode == MODE_MANUAL));
  assign conflict_evt = (mode == MODE_CONFLICT);
endmodule

// File: rtl/pec_engine.sv
module pec_engine
  import pec_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 auto_en,
  input  logic                 manual_pec_en,
  input  logic [BYTE_W-1:0]    sw_pec_data,
  input  logic                 start_evt,
  input  logic                 byte_vld,
  input  logic                 byte_rx,
  input  logic                 byte_last,
  input  logic [BYTE_W-1:0]    byte_data,
  input  logic [NUM_FLAGS-1:0] status_clr,
  output logic [BYTE_W-1:0]    pec_byte,
  output logic                 pec_append,
  output logic                 dev_err,
  output logic                 crc_err,
  output logic                 cfg_conflict
);
  pec_mode_e            mode;
  byte_t                seed;
  byte_t                crc_q_w;
  logic                 acc_upd;
  logic                 check_evt;
  logic                 mismatch_evt;
  logic                 append_req;
  logic                 conflict_evt;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 append_r;

  assign mode = decode_mode(auto_en, manual_pec_en);

  pec_crc_accum #(.POLY(POLY), .INIT(INIT)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .reseed (start_evt),
    .upd    (acc_upd),
    .din    (byte_data),
    .seed   (seed),
    .crc_q  (crc_q_w)
  );

  pec_ctrl u_ctrl (
    .mode         (mode),
    .byte_vld     (byte_vld),
    .byte_rx      (byte_rx),
    .byte_last    (byte_last),
    .byte_data    (byte_data),
    .seed         (seed),
    .acc_upd      (acc_upd),
    .check_evt    (check_evt),
    .mismatch_evt (mismatch_evt),
    .append_req   (append_req),
    .conflict_evt (conflict_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_DEV] = mismatch_evt;
    flag_set[FLAG_CRC] = mismatch_evt;
    flag_set[FLAG_CFG] = conflict_evt;
  end

  pec_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (status_clr),
    .flag_q (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) append_r <= 1'b0;
    else        append_r <= append_req;
  end

  assign pec_byte     = (mode == MODE_MANUAL) ? sw_pec_data : crc_q_w;
  assign pec_append   = append_r;
  assign dev_err      = flag_q[FLAG_DEV];
  assign crc_err      = flag_q[FLAG_CRC];
  assign cfg_conflict = flag_q[FLAG_CFG];
endmodule

// File: rtl/pec_engine_chk.sv
module pec_engine_chk #(
  parameter logic [7:0] INIT = 8'h00
) (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_en,
  input logic       manual_pec_en,
  input logic       start_evt,
  input logic       byte_vld,
  input logic       byte_rx,
  input logic       byte_last,
  input logic [2:0] status_clr,
  input logic       pec_append,
  input logic       dev_err,
  input logic       crc_err,
  input logic       cfg_conflict,
  input logic [7:0] crc_q,
  input logic       mismatch_evt
);
  assert_append_after_tx_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pec_append |-> $past(byte_vld && !byte_rx && byte_last));

  assert_mismatch_sets_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> (dev_err && crc_err));

  assert_start_reseeds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !byte_vld) |=> (crc_q == INIT));

  assert_conflict_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && manual_pec_en) |=> cfg_conflict);

  assert_no_append_in_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pec_append |-> !$past(auto_en && manual_pec_en));

  assert_dev_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_err && !status_clr[0]) |=> dev_err);

  assert_crc_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !status_clr[1]) |=> crc_err);

  assert_idle_holds_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !start_evt) |=> $stable(crc_q));
endmodule

bind pec_engine pec_engine_chk #(.INIT(INIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .auto_en       (auto_en),
  .manual_pec_en (manual_pec_en),
  .start_evt     (start_evt),
  .byte_vld      (byte_vld),
  .byte_rx       (byte_rx),
  .byte_last     (byte_last),
  .status_clr    (status_clr),
  .pec_append    (pec_append),
  .dev_err       (dev_err),
  .crc_err       (crc_err),
  .cfg_conflict  (cfg_conflict),
  .crc_q         (crc_q_w),
  .mismatch_evt  (mismatch_evt)
);

// File: tb/pec_engine_test.sv
module pec_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_en = 1'b0;
  logic       manual_pec_en = 1'b0;
  logic [7:0] sw_pec_data = 8'h00;
  logic       start_evt = 1'b0;
  logic       byte_vld = 1'b0;
  logic       byte_rx = 1'b0;
  logic       byte_last = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [2:0] status_clr = 3'b000;
  logic [7:0] pec_byte;
  logic       pec_append;
  logic       dev_err;
  logic       crc_err;
  logic       cfg_conflict;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pec_engine uut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .manual_pec_en(manual_pec_en),
    .sw_pec_data(sw_pec_data), .start_evt(start_evt), .byte_vld(byte_vld),
    .byte_rx(byte_rx), .byte_last(byte_last), .byte_data(byte_data),
    .status_clr(status_clr), .pec_byte(pec_byte), .pec_append(pec_append),
    .dev_err(dev_err), .crc_err(crc_err), .cfg_conflict(cfg_conflict)
  );

  // Bit-serial model: one message bit at a time into an 8-bit LFSR.
  function automatic logic [7:0] ref_crc(input logic [7:0] acc, input logic [7:0] b);
    logic [7:0] c;
    logic fb;
    c = acc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // {rx, nbytes-1, corrupt, pad[3:0], b0, b1, b2, b3}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 4'h0, 32'hA6000000},
    {1'b0, 2'd2, 1'b0, 4'h0, 32'hA6123400},
    {1'b0, 2'd3, 1'b0, 4'h0, 32'hB0FF005A},
    {1'b0, 2'd1, 1'b0, 4'h0, 32'h16800000},
    {1'b1, 2'd1, 1'b0, 4'h0, 32'hA73C0000},
    {1'b1, 2'd2, 1'b1, 4'h0, 32'hA7010200},
    {1'b1, 2'd3, 1'b0, 4'h0, 32'h17FEDCBA},
    {1'b1, 2'd0, 1'b1, 4'h0, 32'h55000000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic rx, input logic last,
                      input logic [2:0] clr, input logic st);
    byte_vld = 1'b1; byte_data = d; byte_rx = rx; byte_last = last;
    status_clr = clr; start_evt = st;
    @(posedge clk); @(negedge clk);
    byte_vld = 1'b0; byte_last = 1'b0; status_clr = 3'b000; start_evt = 1'b0;
  endtask

  task automatic start_pkt();
    start_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    start_evt = 1'b0;
  endtask

  task automatic clear_all();
    status_clr = 3'b111;
    @(posedge clk); @(negedge clk);
    status_clr = 3'b000;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] m;
    logic [7:0] cnt;
    string s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    auto_en = 1'b1;
    chk("R10 flags", {5'b0, cfg_conflict, crc_err, dev_err}, 8'h00);
    chk("R10 append", {7'b0, pec_append}, 8'h00);
    chk("R10 crc", pec_byte, 8'h00);

    // Vector table walk (R1..R4)
    for (int v = 0; v < NV; v++) begin
      m = 8'h00;
      cnt = {6'b0, VEC[v][38:37]} + 8'd1;
      start_pkt();
      for (int k = 0; k < int'(cnt); k++) begin
        logic [7:0] b;
        b = VEC[v][31 - 8*k -: 8];
        if (!VEC[v][39]) begin
          send(b, 1'b0, (k == int'(cnt) - 1), 3'b000, 1'b0);
        end else begin
          send(b, 1'b1, 1'b0, 3'b000, 1'b0);
        end
        m = ref_crc(m, b);
      end
      if (!VEC[v][39]) begin
        s = $sformatf("R2 append vec%0d", v);
        chk(s, {7'b0, pec_append}, 8'h01);
        s = $sformatf("R1 crc vec%0d", v);
        chk(s, pec_byte, m);
      end else begin
        send(m ^ {7'b0, VEC[v][36]}, 1'b1, 1'b1, 3'b000, 1'b0);
        s = $sformatf("R3/R4 crc_err vec%0d", v);
        chk(s, {7'b0, crc_err}, {7'b0, VEC[v][36]});
        s = $sformatf("R3/R4 dev_err vec%0d", v);
        chk(s, {7'b0, dev_err}, {7'b0, VEC[v][36]});
        chk("R2 no append on read", {7'b0, pec_append}, 8'h00);
      end
      idle(1);
      chk("R2 append single cycle", {7'b0, pec_append}, 8'h00);
      clear_all();
    end

    // R1: known check value
    start_pkt();
    for (int k = 0; k < 9; k++) send(8'h31 + 8'(k), 1'b0, (k == 8), 3'b000, 1'b0);
    chk("R1 check value 123456789", pec_byte, 8'hF4);

    // R6: auto mode ignores software byte; manual mode uses it
    sw_pec_data = 8'hA5;
    start_pkt();
    send(8'h40, 1'b0, 1'b0, 3'b000, 1'b0);
    send(8'h41, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R6 auto crc not sw", pec_byte, ref_crc(ref_crc(8'h00, 8'h40), 8'h41));
    auto_en = 1'b0; manual_pec_en = 1'b1;
    start_pkt();
    send(8'h40, 1'b0, 1'b0, 3'b000, 1'b0);
    send(8'h41, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R6 manual append", {7'b0, pec_append}, 8'h01);
    chk("R6 manual byte", pec_byte, 8'hA5);
    chk("R6 manual no conflict", {7'b0, cfg_conflict}, 8'h00);

    // R7: both enables
    auto_en = 1'b1;
    start_pkt();
    chk("R7 conflict flag", {7'b0, cfg_conflict}, 8'h01);
    send(8'h40, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R7 append suppressed", {7'b0, pec_append}, 8'h00);
    manual_pec_en = 1'b0;
    idle(3);
    chk("R8 conflict sticky", {7'b0, cfg_conflict}, 8'h01);
    clear_all();
    chk("R8 conflict cleared", {7'b0, cfg_conflict}, 8'h00);

    // R8: stickiness, selective clear, set wins over clear
    start_pkt();
    send(8'h11, 1'b1, 1'b0, 3'b000, 1'b0);
    send(8'h00, 1'b1, 1'b1, 3'b000, 1'b0);
    idle(4);
    chk("R8 sticky flags", {6'b0, crc_err, dev_err}, 8'h03);
    status_clr = 3'b010;
    @(posedge clk); @(negedge clk);
    status_clr = 3'b000;
    chk("R8 bit1 clears crc_err only", {6'b0, crc_err, dev_err}, 8'h01);
    clear_all();
    start_pkt();
    send(8'h11, 1'b1, 1'b0, 3'b000, 1'b0);
    send(8'h00, 1'b1, 1'b1, 3'b011, 1'b0);
    chk("R8 set wins over clear", {6'b0, crc_err, dev_err}, 8'h03);
    clear_all();

    // R5: start in same cycle as first byte
    send(8'hC3, 1'b0, 1'b0, 3'b000, 1'b0);
    send(8'h22, 1'b0, 1'b0, 3'b000, 1'b1);
    send(8'h33, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R5 reseed with byte", pec_byte, ref_crc(ref_crc(8'h00, 8'h22), 8'h33));

    // R9: disabled engine neither accumulates nor checks
    start_pkt();
    auto_en = 1'b0;
    send(8'h5A, 1'b1, 1'b0, 3'b000, 1'b0);
    send(8'h00, 1'b1, 1'b1, 3'b000, 1'b0);
    chk("R9 no check when off", {6'b0, crc_err, dev_err}, 8'h00);
    auto_en = 1'b1;
    send(8'h7E, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R9 no accumulation when off", pec_byte, ref_crc(8'h00, 8'h7E));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule